// File: doc/BRIEF.md
# Burst Frame Receiver with M-Channel Superframe Sync

This block takes the serial bit stream of one received line burst, one bit per valid cycle, plus a per-bit code-violation flag produced by the line decoder. A start pulse marks the first bit of each frame. The block collects the 38-bit frame and checks its leading framing bit. It then presents the two octets of each B channel, the four-bit D field and the single M bit, together with a one-cycle frame strobe.

The M bits of successive frames form a four-frame superframe. A code violation carried on the M bit marks the first superframe position. The receiver hunts for that marker and declares lock once the marker repeats four frames later. While locked, it gathers the two transparent-channel bits and the service-channel bit of each superframe and hands them out with a strobe. It drops lock when the marker goes missing twice in a row. Code violations anywhere else in the frame are counted as line errors. Bits that arrive after the M bit, such as an optional DC-balancing bit, are dropped.

Top module: `burst_frame_rx`

## Requirements
- R1: A frame is the 38 valid bits that start with the bit carrying `sof_i`. The frame is the framing bit, then B1 octet A, B2 octet A, D (4 bits), B1 octet B, B2 octet B, and M last. Each field arrives MSB first. One cycle after the M bit is taken, `b1_o` = {B1 A, B1 B}, `b2_o` = {B2 A, B2 B}, `d_o` and `m_o` hold the frame. If the framing bit was 1, `frm_vld_o` is high for exactly that one cycle.
- R2: A frame whose framing bit is 0 raises no `frm_vld_o`. It sets `frm_err_o`, which stays 1 until reset. The M bit of that frame still takes part in superframe sync.
- R3: Valid bits are ignored after the M bit (for example a DC-balancing bit, even one flagged as a violation) and whenever no frame is open. They cause no strobe and no counter change.
- R4: A `sof_i` that arrives in the middle of a frame abandons the partial frame and starts a new one with that bit.
- R5: Lock (`lock_o` = 1) is declared one cycle after the M bit of a frame that carries a violation at M, when the frame four frames earlier also carried a violation at M.
- R6: A single violation at M with no repeat four frames later does not produce lock.
- R7: While locked, one superframe-start frame without an M violation keeps lock. A second consecutive one clears `lock_o` one cycle after its M bit.
- R8: While locked, one cycle after the M bit of superframe position 4, `sf_vld_o` pulses. At that point `t_o[1]` is the M bit of position 2, `t_o[0]` is the M bit of position 4, and `s_o` is the M bit of position 3.
- R9: While not locked, `sf_vld_o` stays 0 and `t_o`/`s_o` keep their last values.
- R10: A violation flagged on any in-frame bit other than M increments `cv_err_cnt_o` by one, saturating at all ones. It does not shift the superframe phase.
- R11: After reset, all strobes, `lock_o`, `frm_err_o` and `cv_err_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | First bit of a frame (qualified by bit_vld_i) |
| bit_vld_i | input | 1 | A received bit is present |
| bit_i | input | 1 | Received bit value |
| cv_i | input | 1 | Code violation detected on this bit |
| b1_o | output | 16 | B1 octets, first-received octet in the upper byte |
| b2_o | output | 16 | B2 octets, first-received octet in the upper byte |
| d_o | output | 4 | D-channel bits |
| m_o | output | 1 | M bit of the frame |
| frm_vld_o | output | 1 | One-cycle strobe for a well-framed frame |
| frm_err_o | output | 1 | Sticky framing-bit error |
| lock_o | output | 1 | Superframe lock held |
| sf_vld_o | output | 1 | One-cycle strobe for new T/S bits |
| t_o | output | 2 | Transparent bits: [1] position 2, [0] position 4 |
| s_o | output | 1 | Service bit (position 3) |
| cv_err_cnt_o | output | 8 | Count of violations off the M slot |

## Verification
The bench first drives a lone M-slot violation, which must not lock, and then its repeat four frames later, which must. A design that locks on the first marker, or counts frames wrongly, shows the wrong `lock_o` after those frames. A violation planted on a B bit inside a locked superframe checks that the T/S positions stay put: a design that re-phased on it would swap T and S values at the scoreboard. The tests also cover a framing-bit-0 frame that still carries the sync marker, a violation-flagged DC bit after M, stray bits with no frame open, and a restart in mid-frame. Each of these would show as a spurious or missing strobe, or a counter change. The tests end by removing two markers and confirming that one miss is tolerated, while after two the T/S strobe stops and the outputs hold.

// File: rtl/brx_pkg.sv
package brx_pkg;

   typedef enum logic [1:0] {
      SF_HUNT = 2'd0,
      SF_CAND = 2'd1,
      SF_LOCK = 2'd2
   } sf_state_e;

   // frame = framing bit + 4 octets + D field + M bit
   function automatic int frame_bits(input int oct_w, input int dch_w);
      return 2 + 4 * oct_w + dch_w;
   endfunction

endpackage

// File: rtl/brx_bit_slicer.sv
module brx_bit_slicer
   import brx_pkg::*;
#(
   parameter int B_W = 8,
   parameter int D_W = 4,
   localparam int FL = frame_bits(B_W, D_W),
   localparam int POS_W = $clog2(FL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof_i,
   input  logic          bit_vld_i,
   input  logic          bit_i,
   input  logic          cv_i,
   output logic          frm_done_o,
   output logic [FL-1:0] frm_word_o,
   output logic          cv_m_o,
   output logic          cv_data_o
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FL - 1);

   logic [POS_W-1:0] pos_q;
   logic             open_q;
   logic [FL-2:0]    shr_q;
   logic             take;
   logic [POS_W-1:0] cur_pos;
   logic             at_m;

   assign take    = bit_vld_i & (sof_i | open_q);
   assign cur_pos = sof_i ? '0 : pos_q;
   assign at_m    = take & (cur_pos == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         open_q <= 1'b0;
         shr_q  <= '0;
      end else if (take) begin
         shr_q <= {shr_q[FL-3:0], bit_i};
         if (at_m) begin
            open_q <= 1'b0;
            pos_q  <= '0;
         end else begin
            open_q <= 1'b1;
            pos_q  <= cur_pos + POS_W'(1);
         end
      end
   end

   assign frm_done_o = at_m;
   assign frm_word_o = {shr_q, bit_i};
   assign cv_m_o     = at_m & cv_i;
   assign cv_data_o  = take & ~at_m & cv_i;

   // R1
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST);

   // R3
   closed_after_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_m |=> !open_q);

endmodule

// File: rtl/brx_sf_sync.sv
module brx_sf_sync
   import brx_pkg::*;
#(
   parameter int MISS_LIM = 2,
   localparam int MW = $clog2(MISS_LIM + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       m_done_i,
   input  logic       m_bit_i,
   input  logic       m_cv_i,
   output logic       lock_o,
   output logic       sf_vld_o,
   output logic [1:0] t_o,
   output logic       s_o
);

   sf_state_e   st_q;
   logic [1:0]  ph_q;      // superframe position of the next M bit, 0 = marker
   logic [MW-1:0] miss_q;
   logic        ta_q;
   logic        sh_q;
   logic        sf_vld_q;
   logic [1:0]  t_q;
   logic        s_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SF_HUNT;
         ph_q     <= 2'd0;
         miss_q   <= '0;
         ta_q     <= 1'b0;
         sh_q     <= 1'b0;
         sf_vld_q <= 1'b0;
         t_q      <= 2'b00;
         s_q      <= 1'b0;
      end else begin
         sf_vld_q <= 1'b0;
         if (m_done_i) begin
            unique case (st_q)
               SF_HUNT: begin
                  if (m_cv_i) begin
                     st_q <= SF_CAND;
                     ph_q <= 2'd1;
                  end
               end
               SF_CAND: begin
                  if (ph_q == 2'd0) begin
                     if (m_cv_i) begin
                        st_q   <= SF_LOCK;
                        ph_q   <= 2'd1;
                        miss_q <= '0;
                     end else begin
                        st_q <= SF_HUNT;
                     end
                  end else if (m_cv_i) begin
                     ph_q <= 2'd1;
                  end else begin
                     ph_q <= ph_q + 2'd1;
                  end
               end
               SF_LOCK: begin
                  ph_q <= ph_q + 2'd1;
                  unique case (ph_q)
                     2'd0: begin
                        if (m_cv_i) begin
                           miss_q <= '0;
                        end else if (miss_q == MW'(MISS_LIM - 1)) begin
                           st_q   <= SF_HUNT;
                           miss_q <= '0;
                        end else begin
                           miss_q <= miss_q + MW'(1);
                        end
                     end
                     2'd1: ta_q <= m_bit_i;
                     2'd2: sh_q <= m_bit_i;
                     2'd3: begin
                        t_q      <= {ta_q, m_bit_i};
                        s_q      <= sh_q;
                        sf_vld_q <= 1'b1;
                     end
                     default: ;
                  endcase
               end
               default: st_q <= SF_HUNT;
            endcase
         end
      end
   end

   assign lock_o   = (st_q == SF_LOCK);
   assign sf_vld_o = sf_vld_q;
   assign t_o      = t_q;
   assign s_o      = s_q;

   // R9
   ts_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sf_vld_o |-> lock_o);

   // R5
   lock_on_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(m_done_i && m_cv_i));

   // R9
   ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sf_vld_o |-> $stable(t_o) && $stable(s_o));

endmodule

// File: rtl/brx_cv_counter.sv
module brx_cv_counter #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (inc_i && ~&cnt_q)     cnt_q <= cnt_q + CNT_W'(1);
         end

         // R10
         cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q >= $past(cnt_q));
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   endgenerate

   // R10
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_i |=> $stable(cnt_q));

   assign cnt_o = cnt_q;

endmodule

// File: rtl/burst_frame_rx.sv
module burst_frame_rx
   import brx_pkg::*;
#(
   parameter int B_W      = 8,
   parameter int D_W      = 4,
   parameter int CNT_W    = 8,
   parameter int MISS_LIM = 2,
   parameter bit CNT_SAT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   input  logic             cv_i,
   output logic [2*B_W-1:0] b1_o,
   output logic [2*B_W-1:0] b2_o,
   output logic [D_W-1:0]   d_o,
   output logic             m_o,
   output logic             frm_vld_o,
   output logic             frm_err_o,
   output logic             lock_o,
   output logic             sf_vld_o,
   output logic [1:0]       t_o,
   output logic             s_o,
   output logic [CNT_W-1:0] cv_err_cnt_o
);

   localparam int FL     = frame_bits(B_W, D_W);
   localparam int F_IDX  = FL - 1;
   localparam int B1A_HI = FL - 2;
   localparam int B2A_HI = B1A_HI - B_W;
   localparam int D_HI   = B2A_HI - B_W;
   localparam int B1B_HI = D_HI - D_W;
   localparam int B2B_HI = B1B_HI - B_W;

   generate
      if (B_W < 1 || D_W < 1) begin : g_bad_width
         $error("burst_frame_rx: field widths must be positive");
      end
      if (MISS_LIM < 1) begin : g_bad_miss
         $error("burst_frame_rx: MISS_LIM must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("burst_frame_rx: CNT_W must be at least 1");
      end
   endgenerate

   logic          frm_done;
   logic [FL-1:0] frm_word;
   logic          cv_m;
   logic          cv_data;

   brx_bit_slicer #(.B_W(B_W), .D_W(D_W)) slicer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_i      (sof_i),
      .bit_vld_i  (bit_vld_i),
      .bit_i      (bit_i),
      .cv_i       (cv_i),
      .frm_done_o (frm_done),
      .frm_word_o (frm_word),
      .cv_m_o     (cv_m),
      .cv_data_o  (cv_data)
   );

   brx_sf_sync #(.MISS_LIM(MISS_LIM)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .m_done_i (frm_done),
      .m_bit_i  (frm_word[0]),
      .m_cv_i   (cv_m),
      .lock_o   (lock_o),
      .sf_vld_o (sf_vld_o),
      .t_o      (t_o),
      .s_o      (s_o)
   );

   brx_cv_counter #(.CNT_W(CNT_W), .SATURATE(CNT_SAT)) errcnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cv_data),
      .cnt_o (cv_err_cnt_o)
   );

   logic [2*B_W-1:0] b1_q, b2_q;
   logic [D_W-1:0]   d_q;
   logic             m_q, vld_q, ferr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b1_q   <= '0;
         b2_q   <= '0;
         d_q    <= '0;
         m_q    <= 1'b0;
         vld_q  <= 1'b0;
         ferr_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (frm_done) begin
            b1_q  <= {frm_word[B1A_HI -: B_W], frm_word[B1B_HI -: B_W]};
            b2_q  <= {frm_word[B2A_HI -: B_W], frm_word[B2B_HI -: B_W]};
            d_q   <= frm_word[D_HI -: D_W];
            m_q   <= frm_word[0];
            vld_q <= frm_word[F_IDX];
            if (!frm_word[F_IDX]) ferr_q <= 1'b1;
         end
      end
   end

   assign b1_o      = b1_q;
   assign b2_o      = b2_q;
   assign d_o       = d_q;
   assign m_o       = m_q;
   assign frm_vld_o = vld_q;
   assign frm_err_o = ferr_q;

   // R1
   frm_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld_o |=> !frm_vld_o);

   // R2
   ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_err_o |=> frm_err_o);

   // R2
   ferr_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_err_o) |-> !frm_vld_o);

endmodule

// File: tb/burst_frame_rx_tb_top.sv
module burst_frame_rx_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, cv_i = 1'b0;
   logic [15:0] b1_o, b2_o;
   logic [3:0]  d_o;
   logic        m_o, frm_vld_o, frm_err_o, lock_o, sf_vld_o, s_o;
   logic [1:0]  t_o;
   logic [7:0]  cv_err_cnt_o;

   int n_chk = 0;
   int n_err = 0;
   logic [36:0] exp_frm_q[$];
   logic [2:0]  exp_sf_q[$];

   always #(CLK_P/2) clk = ~clk;

   burst_frame_rx dut_i (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .bit_vld_i(bit_vld_i),
      .bit_i(bit_i), .cv_i(cv_i), .b1_o(b1_o), .b2_o(b2_o), .d_o(d_o),
      .m_o(m_o), .frm_vld_o(frm_vld_o), .frm_err_o(frm_err_o),
      .lock_o(lock_o), .sf_vld_o(sf_vld_o), .t_o(t_o), .s_o(s_o),
      .cv_err_cnt_o(cv_err_cnt_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor, sampled away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (frm_vld_o) begin
            if (exp_frm_q.size() == 0) chk("R1/R2/R3 unexpected frame strobe", 64'(frm_vld_o), 64'd0);
            else chk("R1 frame fields", 64'({b1_o, b2_o, d_o, m_o}), 64'(exp_frm_q.pop_front()));
         end
         if (sf_vld_o) begin
            if (exp_sf_q.size() == 0) chk("R9 unexpected T/S strobe", 64'(sf_vld_o), 64'd0);
            else chk("R8 T/S bits", 64'({t_o, s_o}), 64'(exp_sf_q.pop_front()));
         end
      end
   end

   task automatic drive_bit(input logic sof, input logic b, input logic cv);
      @(negedge clk);
      sof_i = sof; bit_vld_i = 1'b1; bit_i = b; cv_i = cv;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sof_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0; cv_i = 1'b0;
      end
   endtask

   // cvpos: in-frame bit index (0 = framing bit) flagged as violation, -1 none
   task automatic send_frame(input logic fb, input logic [7:0] a1, input logic [7:0] a2,
                             input logic [3:0] dd, input logic [7:0] c1, input logic [7:0] c2,
                             input logic mb, input logic mcv, input int cvpos, input logic dc);
      logic [37:0] v;
      v = {fb, a1, a2, dd, c1, c2, mb};
      if (fb) exp_frm_q.push_back({a1, c1, a2, c2, dd, mb});
      for (int i = 0; i < 38; i++)
         drive_bit(i == 0, v[37-i], (i == 37) ? mcv : (i == cvpos));
      if (dc) drive_bit(1'b0, 1'b1, 1'b1);
      idle(2);
   endtask

   // plain M frame with a given marker flag and M value
   task automatic m_frame(input logic mb, input logic mcv, input int cvpos);
      send_frame(1'b1, 8'h3C, 8'hA5, 4'h9, 8'h0F, 8'hE1, mb, mcv, cvpos, 1'b0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      idle(3);
      // R11 reset state
      chk("R11 frm_vld", 64'(frm_vld_o), 64'd0);
      chk("R11 lock", 64'(lock_o), 64'd0);
      chk("R11 frm_err", 64'(frm_err_o), 64'd0);
      chk("R11 cnt", 64'(cv_err_cnt_o), 64'd0);
      chk("R11 sf_vld", 64'(sf_vld_o), 64'd0);
      rst_n = 1'b1;
      idle(2);

      // R1 distinct patterns; R3 DC bit after M ignored
      send_frame(1'b1, 8'h81, 8'h7E, 4'h5, 8'hC3, 8'h18, 1'b0, 1'b0, -1, 1'b0);
      send_frame(1'b1, 8'h12, 8'h34, 4'hA, 8'h56, 8'h78, 1'b1, 1'b0, -1, 1'b1);
      chk("R3 DC bit no count", 64'(cv_err_cnt_o), 64'd0);

      // R6 single marker does not lock
      m_frame(1'b0, 1'b1, -1);
      chk("R6 no lock after one marker", 64'(lock_o), 64'd0);
      m_frame(1'b0, 1'b0, -1);
      m_frame(1'b1, 1'b0, -1);
      m_frame(1'b0, 1'b0, -1);
      chk("R6 still unlocked", 64'(lock_o), 64'd0);
      // R5 repeat four frames later locks
      m_frame(1'b0, 1'b1, -1);
      chk("R5 lock after repeat", 64'(lock_o), 64'd1);

      // R8 positions 2..4; R10 violation on a B bit mid-superframe
      m_frame(1'b1, 1'b0, 5);
      chk("R10 counter incremented", 64'(cv_err_cnt_o), 64'd1);
      m_frame(1'b1, 1'b0, -1);
      exp_sf_q.push_back({2'b10, 1'b1});
      m_frame(1'b0, 1'b0, -1);

      // R2 framing bit 0 with marker still syncs; R3 flagged DC bit ignored
      send_frame(1'b0, 8'hFF, 8'h00, 4'h0, 8'hFF, 8'h00, 1'b0, 1'b1, -1, 1'b1);
      chk("R2 frm_err set", 64'(frm_err_o), 64'd1);
      chk("R3 flagged DC bit not counted", 64'(cv_err_cnt_o), 64'd1);
      chk("R2 lock kept", 64'(lock_o), 64'd1);
      m_frame(1'b0, 1'b0, 19);
      chk("R10 D-bit violation counted", 64'(cv_err_cnt_o), 64'd2);
      m_frame(1'b0, 1'b0, -1);
      exp_sf_q.push_back({2'b01, 1'b0});
      m_frame(1'b1, 1'b0, -1);

      // R7 one missing marker tolerated
      m_frame(1'b0, 1'b0, -1);
      chk("R7 lock after one miss", 64'(lock_o), 64'd1);
      m_frame(1'b1, 1'b0, -1);
      m_frame(1'b0, 1'b0, -1);
      exp_sf_q.push_back({2'b11, 1'b0});
      m_frame(1'b1, 1'b0, -1);
      // second consecutive miss drops lock
      m_frame(1'b0, 1'b0, -1);
      chk("R7 lock lost", 64'(lock_o), 64'd0);

      // R9 no T/S strobe and outputs hold while unlocked
      m_frame(1'b0, 1'b0, -1);
      m_frame(1'b0, 1'b0, -1);
      m_frame(1'b0, 1'b0, -1);
      chk("R9 t_o held", 64'(t_o), 64'd3);
      chk("R9 s_o held", 64'(s_o), 64'd0);

      // R3 stray bits with no open frame
      for (int i = 0; i < 6; i++) drive_bit(1'b0, 1'b1, 1'b1);
      idle(3);
      chk("R3 stray bits not counted", 64'(cv_err_cnt_o), 64'd2);

      // R4 restart mid-frame: partial frame discarded
      for (int i = 0; i < 12; i++) drive_bit(i == 0, 1'b1, 1'b0);
      send_frame(1'b1, 8'hDE, 8'hAD, 4'h6, 8'hBE, 8'hEF, 1'b1, 1'b0, -1, 1'b0);
      idle(3);

      chk("R2 frm_err sticky", 64'(frm_err_o), 64'd1);
      chk("R1/R4 frame queue drained", 64'(exp_frm_q.size()), 64'd0);
      chk("R8 T/S queue drained", 64'(exp_sf_q.size()), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule